// File: doc/BRIEF.md
# March C- Memory Self-Test Engine

This block drives a word-wide single-port synchronous SRAM through the six-element March C- sequence. It runs one memory operation per clock and issues 10 operations per tested word. The sweep covers only the ordinary word window, from address 0 up to `2**AW - RSV - 1`. The top `RSV` words are held back as spare words and are never touched. Each element writes or expects a uniform background of all zeros or all ones.

Read data returns one cycle after the read is issued. The engine compares it against the background it expects. On a mismatch it raises a single-cycle error flag together with the address of that read, so a separate repair block can record the failing word while the sweep continues. At the end of the run the engine reports completion and a sticky overall fail status.

A new start after completion clears both the done and fail status and runs the whole sequence again. This allows the memory to be re-tested once the failing words have been remapped.

Top module: `mtest_engine`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `mem_ce` and `cmp_err` are all 0.
- R2: A `start` pulse sampled while `busy` is 0 begins a run, and the first memory operation appears in the very next cycle.
- R3: A run issues exactly 10·N operations on consecutive cycles with no gaps, where N = 2**AW − RSV. The elements come in this order: write 0 ascending; read 0 then write 1 ascending; read 1 then write 0 ascending; read 0 then write 1 descending; read 1 then write 0 descending; read 0 descending. Within an element, each word's read comes before its write.
- R4: Ascending elements visit addresses 0 to N−1, and descending elements visit N−1 down to 0. No address at N or above is ever driven with `mem_ce` high, so faults there never affect the result.
- R5: `mem_ce` is high exactly on operation cycles, and `mem_we` is 1 for a write and 0 for a read. On a write, `mem_wdata` is all zeros for a "write 0" and all ones for a "write 1".
- R6: Read data is compared in the cycle after the read is issued. A mismatch raises `cmp_err` for that one cycle, with `err_addr` equal to the address of that read.
- R7: `fail` rises in the cycle after the first mismatch and holds until the next accepted `start`.
- R8: After the final read there is one cycle with `busy` high and `mem_ce` low. From then on, `done` is 1 and `busy` is 0 until the next accepted `start`.
- R9: An accepted `start` after completion clears `done` and `fail` and repeats the full sequence.
- R10: A `start` pulse while `busy` is 1 has no effect on the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run when not busy |
| mem_rdata | input | DW | Read data from the memory, valid one cycle after a read |
| mem_ce | output | 1 | Memory chip enable, active high |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write data (background pattern) |
| cmp_err | output | 1 | Read mismatch this cycle |
| err_addr | output | AW | Address of the mismatching read |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run complete |
| fail | output | 1 | At least one mismatch in the current or last run |

## Verification
The bench injects faults at the edges of the tested window: stuck-at-1 at address 0 and stuck-at-0 at the top tested word. An off-by-one turn-around there would miss the final descending read, which only the flush cycle catches, or would step into the spare area. A fault placed inside the spare window must leave `fail` low; a sweep that ran over the full array would flag it. The bench also checks that a mid-run `start` pulse is ignored, and that a re-run after the fault is cleared drops `fail`. A design that restarted on that pulse or kept a stale status would then diverge from the cycle-level reference.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } mt_state_e;

  localparam logic [2:0] ELEM_FIRST = 3'd0;
  localparam logic [2:0] ELEM_LAST  = 3'd5;

  // elements 3..5 walk the window downward
  function automatic logic elem_down(input logic [2:0] e);
    return (e >= 3'd3);
  endfunction

  // every element except the first starts each word with a read
  function automatic logic elem_has_rd(input logic [2:0] e);
    return (e != 3'd0);
  endfunction

  // every element except the last ends each word with a write
  function automatic logic elem_has_wr(input logic [2:0] e);
    return (e != 3'd5);
  endfunction

  // background expected by the read of an element
  function automatic logic elem_rd_ones(input logic [2:0] e);
    return (e == 3'd2) || (e == 3'd4);
  endfunction

  // background laid down by the write of an element
  function automatic logic elem_wr_ones(input logic [2:0] e);
    return (e == 3'd1) || (e == 3'd3);
  endfunction

endpackage

// File: rtl/mtest_seq.sv
module mtest_seq
  import mtest_pkg::*;
#(
  parameter int AW  = 12,
  parameter int RSV = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          op_valid,
  output logic          op_we,
  output logic          op_ones,
  output logic [AW-1:0] op_addr,
  output logic          busy,
  output logic          done,
  output logic          go
);

  localparam int WORDS = (1 << AW) - RSV;
  localparam logic [AW-1:0] TOP = AW'(WORDS - 1);

  mt_state_e     st_q;
  logic [2:0]    elem_q;
  logic [AW-1:0] addr_q;
  logic          wr_q;

  logic          word_end;
  logic          elem_end;
  logic          run_end;
  logic [2:0]    elem_nx;

  always_comb begin
    word_end = wr_q || !elem_has_wr(elem_q);
    elem_end = word_end && (elem_down(elem_q) ? (addr_q == '0) : (addr_q == TOP));
    run_end  = elem_end && (elem_q == ELEM_LAST);
    elem_nx  = elem_q + 3'd1;
  end

  assign busy     = (st_q == ST_RUN) || (st_q == ST_FLUSH);
  assign done     = (st_q == ST_DONE);
  assign go       = start && !busy;
  assign op_valid = (st_q == ST_RUN);
  assign op_we    = wr_q;
  assign op_addr  = addr_q;
  assign op_ones  = wr_q ? elem_wr_ones(elem_q) : elem_rd_ones(elem_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      elem_q <= ELEM_FIRST;
      addr_q <= '0;
      wr_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            st_q   <= ST_RUN;
            elem_q <= ELEM_FIRST;
            addr_q <= '0;
            wr_q   <= !elem_has_rd(ELEM_FIRST);
          end
        end
        ST_RUN: begin
          if (!word_end) begin
            wr_q <= 1'b1;
          end else if (run_end) begin
            st_q <= ST_FLUSH;
            wr_q <= 1'b0;
          end else if (elem_end) begin
            elem_q <= elem_nx;
            addr_q <= elem_down(elem_nx) ? TOP : '0;
            wr_q   <= !elem_has_rd(elem_nx);
          end else begin
            addr_q <= elem_down(elem_q) ? (addr_q - AW'(1)) : (addr_q + AW'(1));
            wr_q   <= !elem_has_rd(elem_q);
          end
        end
        default: st_q <= ST_DONE;
      endcase
    end
  end

  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (op_addr <= TOP)); // R4

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && $past(op_valid) && $past(word_end) && !$past(elem_end))
      |-> ((op_addr == $past(op_addr) + AW'(1)) || (op_addr == $past(op_addr) - AW'(1)))); // R4

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done)); // R10

endmodule

// File: rtl/mtest_cmp.sv
module mtest_cmp #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_issue,
  input  logic [AW-1:0] rd_addr,
  input  logic          rd_ones,
  input  logic [DW-1:0] rdata,
  output logic          err,
  output logic [AW-1:0] err_addr,
  output logic          fail
);

  logic          rv_q;
  logic          ones_q;
  logic [AW-1:0] addr_q;
  logic          fail_q;
  logic [DW-1:0] expect_w;

  assign expect_w = {DW{ones_q}};
  assign err      = rv_q && (rdata != expect_w);
  assign err_addr = addr_q;
  assign fail     = fail_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q   <= 1'b0;
      ones_q <= 1'b0;
      addr_q <= '0;
      fail_q <= 1'b0;
    end else begin
      rv_q <= rd_issue;
      if (rd_issue) begin
        ones_q <= rd_ones;
        addr_q <= rd_addr;
      end
      if (clear)    fail_q <= 1'b0;
      else if (err) fail_q <= 1'b1;
    end
  end

  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_issue)); // R6

  AST_ERR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (err_addr == $past(rd_addr))); // R6

  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !clear) |=> fail); // R7

  AST_ERR_SETS_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !clear) |=> fail); // R7

endmodule

// File: rtl/mtest_engine.sv
module mtest_engine #(
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int RSV = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_ce,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          cmp_err,
  output logic [AW-1:0] err_addr,
  output logic          busy,
  output logic          done,
  output logic          fail
);

  logic          op_valid;
  logic          op_we;
  logic          op_ones;
  logic [AW-1:0] op_addr;
  logic          go;
  logic          rd_issue;

  mtest_seq #(.AW(AW), .RSV(RSV)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_valid (op_valid),
    .op_we    (op_we),
    .op_ones  (op_ones),
    .op_addr  (op_addr),
    .busy     (busy),
    .done     (done),
    .go       (go)
  );

  assign rd_issue  = op_valid && !op_we;
  assign mem_ce    = op_valid;
  assign mem_we    = op_valid && op_we;
  assign mem_addr  = op_addr;
  assign mem_wdata = {DW{op_valid && op_we && op_ones}};

  mtest_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (go),
    .rd_issue (rd_issue),
    .rd_addr  (op_addr),
    .rd_ones  (op_ones),
    .rdata    (mem_rdata),
    .err      (cmp_err),
    .err_addr (err_addr),
    .fail     (fail)
  );

  AST_CE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce |-> busy); // R5

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_ce)); // R8

  AST_START_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> mem_ce); // R2

endmodule

// File: tb/sim_mtest_engine.sv
module sim_mtest_engine;

  localparam int AW  = 6;
  localparam int DW  = 8;
  localparam int RSV = 4;
  localparam int N   = (1 << AW) - RSV;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_ce, mem_we, cmp_err, busy, done, fail;
  logic [AW-1:0] mem_addr, err_addr;
  logic [DW-1:0] mem_wdata;

  always #5 clk = ~clk;

  mtest_engine #(.AW(AW), .DW(DW), .RSV(RSV)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rdata(mem_rdata),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cmp_err(cmp_err), .err_addr(err_addr), .busy(busy), .done(done), .fail(fail)
  );

  // memory model with one injectable stuck-at word
  logic [DW-1:0] mem [1 << AW];
  logic          f_en = 1'b0;
  int            f_addr = 0;
  logic [DW-1:0] f_s0 = '0;
  logic [DW-1:0] f_s1 = '0;

  always @(posedge clk) begin
    if (mem_ce) begin
      if (mem_we) begin
        if (f_en && (int'(mem_addr) == f_addr)) mem[mem_addr] <= (mem_wdata & ~f_s0) | f_s1;
        else                                    mem[mem_addr] <= mem_wdata;
      end else begin
        mem_rdata <= mem[mem_addr];
      end
    end
  end

  int total = 0;
  int bad   = 0;
  int ops[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // expected operation list: bit9 write, bit8 ones background, low bits address
  task automatic build_ops();
    ops.delete();
    for (int el = 0; el < 6; el++) begin
      int rexp;
      int wval;
      bit dn;
      case (el)
        0: begin rexp = -1; wval = 0;  dn = 0; end
        1: begin rexp = 0;  wval = 1;  dn = 0; end
        2: begin rexp = 1;  wval = 0;  dn = 0; end
        3: begin rexp = 0;  wval = 1;  dn = 1; end
        4: begin rexp = 1;  wval = 0;  dn = 1; end
        default: begin rexp = 0; wval = -1; dn = 1; end
      endcase
      for (int i = 0; i < N; i++) begin
        int a;
        a = dn ? (N - 1 - i) : i;
        if (rexp >= 0) ops.push_back((rexp << 8) | a);
        if (wval >= 0) ops.push_back(512 | (wval << 8) | a);
      end
    end
  endtask

  task automatic run_pass(input string name, input bit fen, input int fa,
                          input logic [DW-1:0] s0, input logic [DW-1:0] s1,
                          input bit poke, input bit want_fail);
    bit prev_rd;
    int prev_a;
    bit prev_o;
    bit fail_exp;
    bit perr;
    f_en = fen; f_addr = fa; f_s0 = s0; f_s1 = s1;
    build_ops();
    prev_rd = 0; prev_a = 0; prev_o = 0; fail_exp = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done == 1'b0, "R9", {name, " done cleared"}, done, 0);
    chk(fail == 1'b0, "R9", {name, " fail cleared"}, fail, 0);
    for (int k = 0; k < ops.size(); k++) begin
      int e;
      bit ew;
      bit eo;
      int ea;
      e  = ops[k];
      ew = e[9];
      eo = e[8];
      ea = e & 255;
      chk(mem_ce == 1'b1, (k == 0) ? "R2" : "R3", {name, " ce"}, mem_ce, 1);
      chk(busy == 1'b1 && done == 1'b0, "R8", {name, " busy"}, busy, 1);
      chk(mem_we == ew, "R3", {name, " we"}, mem_we, ew);
      chk(int'(mem_addr) == ea, "R4", {name, " addr"}, mem_addr, ea);
      if (ew) chk(mem_wdata == {DW{eo}}, "R5", {name, " wdata"}, mem_wdata, eo ? (1 << DW) - 1 : 0);
      perr = prev_rd && fen && (prev_a == fa) && (prev_o ? (s0 != 0) : (s1 != 0));
      chk(cmp_err == perr, "R6", {name, " cmp_err"}, cmp_err, perr);
      if (perr) chk(int'(err_addr) == prev_a, "R6", {name, " err_addr"}, err_addr, prev_a);
      chk(fail == fail_exp, "R7", {name, " fail"}, fail, fail_exp);
      if (perr) fail_exp = 1;
      prev_rd = !ew; prev_a = ea; prev_o = eo;
      start = (poke && k == 100);  // R10: pulse while busy
      @(negedge clk);
    end
    start = 1'b0;
    // flush cycle
    perr = prev_rd && fen && (prev_a == fa) && (prev_o ? (s0 != 0) : (s1 != 0));
    chk(mem_ce == 1'b0 && busy == 1'b1, "R8", {name, " flush"}, mem_ce, 0);
    chk(cmp_err == perr, "R6", {name, " last read"}, cmp_err, perr);
    if (perr) chk(int'(err_addr) == prev_a, "R6", {name, " last err_addr"}, err_addr, prev_a);
    chk(fail == fail_exp, "R7", {name, " fail flush"}, fail, fail_exp);
    if (perr) fail_exp = 1;
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R8", {name, " done"}, done, 1);
    chk(fail == fail_exp, "R7", {name, " final fail"}, fail, fail_exp);
    chk(fail == want_fail, (fen && !want_fail) ? "R4" : "R7", {name, " verdict"}, fail, want_fail);
    chk(cmp_err == 1'b0, "R6", {name, " idle err"}, cmp_err, 0);
    repeat (3) @(negedge clk);
    chk(done == 1'b1 && mem_ce == 1'b0, "R8", {name, " done held"}, done, 1);
    chk(fail == want_fail, "R7", {name, " fail held"}, fail, want_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fail == 0, "R1", "in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", "busy/done", busy, 0);
    chk(fail == 0, "R1", "fail", fail, 0);
    chk(mem_ce == 0 && cmp_err == 0, "R1", "ce/err", mem_ce, 0);
    run_pass("clean",    1'b0, 0,     '0,     '0,     1'b1, 1'b0);
    run_pass("sa0_mid",  1'b1, 17,    8'h08,  '0,     1'b0, 1'b1);
    run_pass("repaired", 1'b0, 0,     '0,     '0,     1'b0, 1'b0);   // R9
    run_pass("sa1_low",  1'b1, 0,     '0,     8'h01,  1'b0, 1'b1);
    run_pass("sa0_top",  1'b1, N - 1, 8'h80,  '0,     1'b0, 1'b1);
    run_pass("spare",    1'b1, N + 2, '0,     8'hFF,  1'b0, 1'b0);   // R4
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R8 watchdog act=%0d exp=%0d", done, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule